// File: doc/BRIEF.md
# Two-Channel Compare Match Timer

This block is a small memory-mapped timer with two independent channels. Each channel divides the peripheral clock by a selectable prescale ratio and counts that tick in an up-counter. When the counter equals its compare value, it returns to zero on the next tick and sets a sticky match flag. If the channel's interrupt enable is set, the flag drives that channel's level interrupt output. A single run register holds one start/stop bit per channel, so software starts and stops every channel through one word.

Software uses the block over a simple synchronous register bus. Writes take effect on the clock edge and reads are combinational. A driver sets the compare value and the clock select, clears the counter, sets the channel's run bit, and services the interrupt by writing the flag back as zero. A write to a counter does not take effect straight away: it is applied on the second count tick after the write. Until then, reads return the running value.

Top module: `cmt_timer`

## Requirements
- R1: After reset, the run register reads 0. Every control/status word, flag, enable and counter reads 0, every compare register reads all ones, and both interrupt outputs are low.
- R2: Registers are one access width wide (ACC bytes, CNT_W/8). The run register is at byte 0. Channel n's block starts at byte ACC + 3·ACC·n and holds control/status, counter and compare at word offsets 0, 1 and 2 (for 16-bit registers: 2/4/6 and 8/10/12). Any other address reads 0.
- R3: Run register bit n starts channel n when 1 and stops it when 0. Each channel counts only on its own bit.
- R4: Control/status bits 1:0 select the count tick as the clock divided by 8, 32, 128 or 512 for codes 0 to 3. The prescaler restarts from zero whenever its run bit is 0, so the first tick lands exactly one division period after the run bit is set.
- R5: On each tick the counter increments. When it already equals the compare value, it goes to 0 instead, so one period is compare+1 ticks.
- R6: A wrap to 0 sets control/status bit 7, the match flag. The flag stays set while no clearing write arrives.
- R7: Writing control/status with bit 7 at 0 clears the flag, and writing bit 7 as 1 leaves it unchanged. Bit 6 (interrupt enable) and bits 1:0 take the written value, and the other bits read 0.
- R8: When a match and a flag-clearing write happen in the same cycle, the flag ends set.
- R9: Interrupt output n is high exactly while channel n's flag and enable are both 1, and stays high until one of them is cleared.
- R10: A counter write is applied on the second count tick after it. The first tick still counts normally, and reads return the old value until the second tick.
- R11: A stopped channel keeps its counter value and never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, applied on the rising edge |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Combinational read data for bus_addr |
| irq_o | output | NCH (2) | Level interrupt per channel |

## Verification
The embedded properties assume that a bus write is a single-cycle strobe with an address and data already stable at the edge. They also assume that reset is held for at least one edge before any access. The stimulus drives every bus signal on the falling edge and raises the strobe for exactly one rising edge. It places flag-clearing writes and counter writes on chosen edges relative to the prescaler phase, which is known from the edge on which the run bit was set. This lets the clear-versus-match collision and the two-tick counter delay land on exact cycles.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Count clock selection codes held in control/status bits 1:0
    typedef enum logic [1:0] {
        CKS_DIV8   = 2'd0,
        CKS_DIV32  = 2'd1,
        CKS_DIV128 = 2'd2,
        CKS_DIV512 = 2'd3
    } cks_e;

    localparam int PSC_W        = 9;
    localparam int CSR_FLAG_BIT = 7;
    localparam int CSR_IE_BIT   = 6;
    localparam int CSR_BITS     = 8;

    // Per-channel control/status content
    typedef struct packed {
        logic flag;
        logic ie;
        cks_e cks;
    } csr_t;

    // Register slots inside one channel block (word offsets)
    typedef enum logic [1:0] {
        SLOT_CSR = 2'd0,
        SLOT_CNT = 2'd1,
        SLOT_CMP = 2'd2
    } slot_e;

    // Terminal prescaler count for a given selection
    function automatic logic [PSC_W-1:0] psc_last(input cks_e sel);
        case (sel)
            CKS_DIV8:   psc_last = PSC_W'(7);
            CKS_DIV32:  psc_last = PSC_W'(31);
            CKS_DIV128: psc_last = PSC_W'(127);
            default:    psc_last = PSC_W'(511);
        endcase
    endfunction

    // Control/status word as seen on the bus
    function automatic logic [CSR_BITS-1:0] csr_pack(input csr_t c);
        csr_pack = {c.flag, c.ie, 4'b0000, c.cks};
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  cks_e cks_i,
    output logic tick_o
);

    logic [PSC_W-1:0] pc_q;
    logic             at_last;

    assign at_last = (pc_q == psc_last(cks_i));
    assign tick_o  = run_i && at_last;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pc_q <= '0;
        end else if (at_last) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PSC_W'(1);
        end
    end

    // R4: a stopped prescaler sits at zero so the restart phase is known
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (pc_q == '0));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             csr_we,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wdata,
    output csr_t             csr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             irq_o
);

    csr_t             csr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [1:0]       pend_q;
    logic             load_now;
    logic             match_ev;

    assign load_now = tick_i && (pend_q == 2'd1) && !cnt_we;
    assign match_ev = tick_i && !load_now && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q      <= '{flag: 1'b0, ie: 1'b0, cks: CKS_DIV8};
            cnt_q      <= '0;
            cmp_q      <= '1;
            pend_val_q <= '0;
            pend_q     <= 2'd0;
        end else begin
            if (cmp_we) begin
                cmp_q <= wdata;
            end

            if (csr_we) begin
                csr_q.ie  <= wdata[CSR_IE_BIT];
                csr_q.cks <= cks_e'(wdata[1:0]);
            end

            // match has priority over a software clear
            if (match_ev) begin
                csr_q.flag <= 1'b1;
            end else if (csr_we && !wdata[CSR_FLAG_BIT]) begin
                csr_q.flag <= 1'b0;
            end

            if (cnt_we) begin
                pend_val_q <= wdata;
                pend_q     <= 2'd2;
            end else if (tick_i && pend_q != 2'd0) begin
                pend_q <= pend_q - 2'd1;
            end

            if (tick_i) begin
                if (load_now) begin
                    cnt_q <= pend_val_q;
                end else if (cnt_q == cmp_q) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign csr_o = csr_q;
    assign cnt_o = cnt_q;
    assign cmp_o = cmp_q;
    assign irq_o = csr_q.flag && csr_q.ie;

    // R5, R6: an equal count on a plain tick wraps to zero and raises the flag
    p_wrap_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (cnt_q == cmp_q) && (pend_q != 2'd1)) |=> ((cnt_q == '0) && csr_q.flag));

    // R7: a clearing write with no tick leaves the flag low
    p_clear_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !wdata[CSR_FLAG_BIT] && !tick_i) |=> !csr_q.flag);

    // R9: the interrupt level holds while the control word is not written
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !csr_we) |=> irq_o);

    // R11: a stopped channel neither moves nor flags
    p_stopped_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> ($stable(cnt_q) && !$rose(csr_q.flag)));

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 16,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [NCH-1:0]   irq_o
);

    localparam int ACC_B = CNT_W / 8;
    localparam int BLK_B = 3 * ACC_B;

    logic [NCH-1:0]   run_q;
    logic             run_sel;
    logic [NCH-1:0]   csr_sel;
    logic [NCH-1:0]   cnt_sel;
    logic [NCH-1:0]   cmp_sel;
    logic [NCH-1:0]   tick_w;
    csr_t             csr_w [NCH];
    logic [CNT_W-1:0] cnt_w [NCH];
    logic [CNT_W-1:0] cmp_w [NCH];

    assign run_sel = (bus_addr == AW'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bus_we && run_sel) begin
            run_q <= bus_wdata[NCH-1:0];
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int BASE = ACC_B + BLK_B * n;

        assign csr_sel[n] = (bus_addr == AW'(BASE + int'(SLOT_CSR) * ACC_B));
        assign cnt_sel[n] = (bus_addr == AW'(BASE + int'(SLOT_CNT) * ACC_B));
        assign cmp_sel[n] = (bus_addr == AW'(BASE + int'(SLOT_CMP) * ACC_B));

        cmt_prescaler u_psc (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run_q[n]),
            .cks_i  (csr_w[n].cks),
            .tick_o (tick_w[n])
        );

        cmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run_q[n]),
            .tick_i (tick_w[n]),
            .csr_we (bus_we && csr_sel[n]),
            .cnt_we (bus_we && cnt_sel[n]),
            .cmp_we (bus_we && cmp_sel[n]),
            .wdata  (bus_wdata),
            .csr_o  (csr_w[n]),
            .cnt_o  (cnt_w[n]),
            .cmp_o  (cmp_w[n]),
            .irq_o  (irq_o[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (run_sel) begin
            bus_rdata[NCH-1:0] = run_q;
        end
        for (int n = 0; n < NCH; n++) begin
            if (csr_sel[n]) begin
                bus_rdata = {{(CNT_W-CSR_BITS){1'b0}}, csr_pack(csr_w[n])};
            end
            if (cnt_sel[n]) begin
                bus_rdata = cnt_w[n];
            end
            if (cmp_sel[n]) begin
                bus_rdata = cmp_w[n];
            end
        end
    end

    // R3: no channel ticks while its run bit is clear
    p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_w & ~run_q) == '0);

endmodule

// File: tb/test_cmt_timer.sv
`timescale 1ns/1ps
module test_cmt_timer;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [1:0]    irq_o;

    int n_vec = 0;
    int n_bad = 0;

    // byte addresses (R2)
    localparam logic [AW-1:0] A_RUN  = 8'd0;
    localparam logic [AW-1:0] A_CSR0 = 8'd2;
    localparam logic [AW-1:0] A_CNT0 = 8'd4;
    localparam logic [AW-1:0] A_CMP0 = 8'd6;
    localparam logic [AW-1:0] A_CSR1 = 8'd8;
    localparam logic [AW-1:0] A_CNT1 = 8'd10;
    localparam logic [AW-1:0] A_CMP1 = 8'd12;

    always #5 clk = ~clk;

    cmt_timer #(.NCH(2), .CNT_W(DW), .AW(AW)) i_cmt_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] held;

        do_reset();
        #1;
        // R1: reset values
        rd(A_RUN, v);  chk("R1 run", v, 0);
        rd(A_CSR0, v); chk("R1 csr0", v, 0);
        rd(A_CNT0, v); chk("R1 cnt0", v, 0);
        rd(A_CMP0, v); chk("R1 cmp0", v, 16'hFFFF);
        rd(A_CSR1, v); chk("R1 csr1", v, 0);
        rd(A_CNT1, v); chk("R1 cnt1", v, 0);
        rd(A_CMP1, v); chk("R1 cmp1", v, 16'hFFFF);
        chk("R1 irq", irq_o, 0);

        // R2: unmapped addresses read zero, mapped compare reads back
        wr(A_CMP1, 16'h1234);
        rd(8'd14, v); chk("R2 unmapped 14", v, 0);
        rd(8'd1, v);  chk("R2 unmapped 1", v, 0);
        rd(A_CMP1, v); chk("R2 cmp1 readback", v, 16'h1234);

        // R4, R5, R6: sweep every prescale code, compare = 3
        for (int code = 0; code < 4; code++) begin
            int div;
            div = 8 << (2 * code);
            do_reset();
            wr(A_CMP0, 16'd3);
            wr(A_CSR0, DW'(code));
            wr(A_RUN, 16'h0001);
            wait_edges(div - 1);
            rd(A_CNT0, v); chk("R4 no tick before division", v, 0);
            wait_edges(1);
            rd(A_CNT0, v); chk("R4 first tick", v, 1);
            for (int k = 2; k <= 6; k++) begin
                wait_edges(div);
                rd(A_CNT0, v); chk("R5 count", v, DW'(k % 4));
                rd(A_CSR0, v); chk("R6 flag", v, {8'h0, (k >= 4), 5'b0, 2'(code)});
            end
            rd(A_CNT1, v); chk("R3 other channel idle", v, 0);
        end

        // R9, R7: enable and clear with the channel stopped (flag set from sweep)
        chk("R9 irq off without enable", irq_o, 2'b00);
        wr(A_RUN, 16'h0000);
        rd(A_CNT0, held);
        wr(A_CSR0, 16'h00C3);
        rd(A_CSR0, v); chk("R7 write one keeps flag", v, 16'h00C3);
        chk("R9 irq on", irq_o, 2'b01);
        wait_edges(3);
        chk("R9 irq level held", irq_o, 2'b01);
        wr(A_CSR0, 16'h007F);
        rd(A_CSR0, v); chk("R7 write zero clears, unused bits zero", v, 16'h0043);
        chk("R9 irq off after clear", irq_o, 2'b00);
        // R11: stopped channel holds and never flags
        wait_edges(2000);
        rd(A_CNT0, v); chk("R11 stopped count held", v, held);
        rd(A_CSR0, v); chk("R11 stopped no flag", v, 16'h0043);

        // R8: clear against match, compare = 0 so every tick matches
        do_reset();
        wr(A_CMP0, 16'd0);
        wr(A_CSR0, 16'h0040);
        wr(A_RUN, 16'h0001);               // edge E0
        wait_edges(11);                    // after E11
        wr(A_CSR0, 16'h0040);              // lands on E12, no tick
        rd(A_CSR0, v); chk("R7 clear between ticks", v, 16'h0040);
        chk("R9 irq low after clear", irq_o, 2'b00);
        wait_edges(3);                     // after E15
        wr(A_CSR0, 16'h0040);              // lands on E16, a tick
        rd(A_CSR0, v); chk("R8 match wins over clear", v, 16'h00C0);
        chk("R8 irq stays high", irq_o, 2'b01);

        // R10: delayed counter write
        do_reset();
        wr(A_CMP0, 16'd1000);
        wr(A_RUN, 16'h0001);               // E0
        wr(A_CNT0, 16'd50);                // E1
        rd(A_CNT0, v); chk("R10 old value right after write", v, 0);
        wait_edges(7);                     // E8: first tick counts
        rd(A_CNT0, v); chk("R10 first tick counts normally", v, 1);
        wait_edges(7);                     // E15
        rd(A_CNT0, v); chk("R10 not yet applied", v, 1);
        wait_edges(1);                     // E16: loaded
        rd(A_CNT0, v); chk("R10 applied on second tick", v, 50);
        wait_edges(8);                     // E24
        rd(A_CNT0, v); chk("R10 counts on from written value", v, 51);

        // R3, R4: channel independence and prescaler restart
        do_reset();
        wr(A_CMP1, 16'd5);
        wr(A_RUN, 16'h0002);               // ch1 at E0
        wait_edges(24);
        rd(A_CNT1, v); chk("R3 ch1 runs alone", v, 3);
        rd(A_CNT0, v); chk("R3 ch0 stays idle", v, 0);
        wr(A_RUN, 16'h0001);               // ch1 stops, ch0 starts
        wait_edges(20);
        rd(A_CNT1, v); chk("R3 ch1 held after stop", v, 3);
        rd(A_CNT0, v); chk("R3 ch0 runs after own bit", v, 2);
        wr(A_RUN, 16'h0003);               // ch1 restarts its prescaler
        wait_edges(7);
        rd(A_CNT1, v); chk("R4 restart no early tick", v, 3);
        wait_edges(1);
        rd(A_CNT1, v); chk("R4 restart full division", v, 4);
        wait_edges(16);
        rd(A_CNT1, v); chk("R5 ch1 wraps at compare", v, 0);
        rd(A_CSR1, v); chk("R6 ch1 flag", v, 16'h0080);

        summary();
        $finish;
    end

endmodule